// File: doc/BRIEF.md
# Asymmetric Dual-Port Block Memory

This block is an 18-Kbit synchronous memory with two access ports, A and B. It holds 16 Kbit of data and 2 Kbit of parity. Each port picks its own shape from six depth-by-width choices: 1, 2, 4, 9, 18 or 36 bits wide. So one side can stream single bits while the other side moves 36-bit words through the same storage. The 9-, 18- and 36-bit shapes carry parity bits next to their data bytes. The narrow shapes see only data.

Inside, storage is 512 words of 32 data bits plus 4 parity bits. A port narrower than a full word selects a slice of a word with its low address bits. Each port has its own output behaviour while it writes: it can show the old contents, show the new data, or hold its last value. A build-time configuration picks one of three port arrangements. In single-port mode, A reads and writes and B is unused. In split mode, A only writes and B only reads. In dual mode, both ports read and write. Both ports run on one shared clock. Every stored bit starts from a build-time constant.

Top module: `asym_dpram`

## Requirements
- R1: A port of width W uses D data bits: D = W for W in {1,2,4}, and D = 8, 16 or 32 for W = 9, 18 or 36. The port holds 32/D slices per word. Port address `a` reaches slice `a mod (32/D)` of word `a / (32/D)`. Slice 0 is the least significant.
- R2: For W = 9, 18 and 36, the top 1, 2 or 4 bits of the port word are parity. They map to parity slice `a mod (32/D)` of the same word. The 1-, 2- and 4-bit shapes never touch parity.
- R3: An enabled port with write enable low loads the addressed contents into its output register at the clock edge.
- R4: In read-first mode, an enabled write loads the port output with the contents the address held before the write.
- R5: In write-first mode, an enabled write loads the port output with the data being written.
- R6: In no-change mode, an enabled write leaves the port output unchanged.
- R7: A port with its enable low writes nothing and its output holds.
- R8: In split mode, port A only writes and its output stays zero. Port B only reads, and its write enable is ignored.
- R9: In single-port mode, port B neither writes nor updates its output, which stays zero.
- R10: Before any write, every word reads back the build-time data constant and parity constant.
- R11: When both ports write the same word in one cycle, bits that only one port targets take that port's data. Bits that both ports target take port A's data.
- R12: An active-low asynchronous reset clears both output registers and leaves the stored contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rstN | input | 1 | Active-low asynchronous reset of the output registers |
| aEn | input | 1 | Port A enable |
| aWe | input | 1 | Port A write enable |
| aAddr | input | log2(WORDS*32/D_A) | Port A address |
| aWdata | input | A_WIDTH | Port A write data, parity in the top bits |
| aRdata | output | A_WIDTH | Port A registered read data |
| bEn | input | 1 | Port B enable |
| bWe | input | 1 | Port B write enable |
| bAddr | input | log2(WORDS*32/D_B) | Port B address |
| bWdata | input | B_WIDTH | Port B write data, parity in the top bits |
| bRdata | output | B_WIDTH | Port B registered read data |

## Verification
The assertions check every cycle that an idle port holds its output. They check the output's behaviour during a write: it echoes the written data in write-first mode and holds in no-change mode. They check that an output which can never read stays zero, and that reset clears both outputs. Stored contents are not visible to the assertions. Slice and parity placement across the two widths, initial contents, old-data return in read-first mode, and merging of writes to one word in the same cycle are shown only by the bench. The bench covers these by reading back through the opposite port in several configurations.

// File: rtl/asym_dpram_pkg.sv
package asym_dpram_pkg;

  localparam int WORD_DATA = 32;
  localparam int WORD_PAR  = 4;

  typedef enum logic [1:0] {READ_FIRST, WRITE_FIRST, NO_CHANGE} wmode_e;
  typedef enum logic [1:0] {CFG_SINGLE, CFG_SPLIT, CFG_DUAL} portcfg_e;

  // strobes from a port controller to the datapath
  typedef struct packed {
    logic wr;    // commit the write into storage
    logic load;  // load output register from storage
    logic echo;  // load output register from write data
  } stb_t;

  function automatic int dataBits(input int w);
    return (w >= 9) ? (w / 9) * 8 : w;
  endfunction

  function automatic int parBits(input int w);
    return (w >= 9) ? (w / 9) : 0;
  endfunction

  function automatic int addrBits(input int w, input int words);
    return $clog2(words * (WORD_DATA / dataBits(w)));
  endfunction

endpackage

// File: rtl/asym_dpram_port_ctrl.sv
module asym_dpram_port_ctrl
  import asym_dpram_pkg::*;
#(
  parameter bit     CAN_WR = 1'b1,
  parameter bit     CAN_RD = 1'b1,
  parameter wmode_e WMODE  = READ_FIRST
) (
  input  logic en,
  input  logic we,
  output stb_t stb
);

  always_comb begin
    stb = '0;
    if (en) begin
      if (we && CAN_WR) begin
        stb.wr = 1'b1;
        if (CAN_RD) begin
          case (WMODE)
            READ_FIRST:  stb.load = 1'b1;
            WRITE_FIRST: stb.echo = 1'b1;
            default:     ;
          endcase
        end
      end else if (CAN_RD) begin
        stb.load = 1'b1;
      end
    end
  end

endmodule

// File: rtl/asym_dpram_lane_map.sv
module asym_dpram_lane_map
  import asym_dpram_pkg::*;
#(
  parameter int WIDTH = 9,
  parameter int WORDS = 512,
  localparam int D  = dataBits(WIDTH),
  localparam int P  = parBits(WIDTH),
  localparam int AW = addrBits(WIDTH, WORDS),
  localparam int WW = $clog2(WORDS)
) (
  input  logic [AW-1:0]        addr,
  input  logic [WIDTH-1:0]     wdata,
  input  logic [WORD_DATA-1:0] memData,
  input  logic [WORD_PAR-1:0]  memPar,
  output logic [WW-1:0]        wordIdx,
  output logic [WORD_DATA-1:0] dMask,
  output logic [WORD_DATA-1:0] dVal,
  output logic [WORD_PAR-1:0]  pMask,
  output logic [WORD_PAR-1:0]  pVal,
  output logic [WIDTH-1:0]     rdData
);

  localparam int LANES = WORD_DATA / D;
  localparam int LB    = $clog2(LANES);
  localparam logic [WORD_DATA-1:0] DONES = WORD_DATA'((64'd1 << D) - 64'd1);

  logic [4:0]           lane;
  logic [WORD_DATA-1:0] dShift;

  assign wordIdx = addr[AW-1:LB];

  generate
    if (LB == 0) begin : g_full
      assign lane = '0;
    end else begin : g_slice
      assign lane = 5'(addr[LB-1:0]);
    end
  endgenerate

  assign dMask  = DONES << (lane * D);
  assign dVal   = WORD_DATA'(wdata[D-1:0]) << (lane * D);
  assign dShift = memData >> (lane * D);

  generate
    if (P > 0) begin : g_par
      localparam logic [WORD_PAR-1:0] PONES = WORD_PAR'((8'd1 << P) - 8'd1);
      logic [WORD_PAR-1:0] pShift;
      assign pMask  = PONES << (lane * P);
      assign pVal   = WORD_PAR'(wdata[WIDTH-1:D]) << (lane * P);
      assign pShift = memPar >> (lane * P);
      assign rdData = {pShift[P-1:0], dShift[D-1:0]};
    end else begin : g_nopar
      logic unusedPar;
      assign unusedPar = ^memPar;
      assign pMask  = '0;
      assign pVal   = '0;
      assign rdData = dShift[D-1:0];
    end
  endgenerate

endmodule

// File: rtl/asym_dpram_datapath.sv
module asym_dpram_datapath
  import asym_dpram_pkg::*;
#(
  parameter int A_WIDTH = 9,
  parameter int B_WIDTH = 36,
  parameter int WORDS   = 512,
  parameter logic [WORD_DATA-1:0] INIT_DATA = '0,
  parameter logic [WORD_PAR-1:0]  INIT_PAR  = '0,
  localparam int AAW = addrBits(A_WIDTH, WORDS),
  localparam int BAW = addrBits(B_WIDTH, WORDS),
  localparam int WW  = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  stb_t               stbA,
  input  stb_t               stbB,
  input  logic [AAW-1:0]     aAddr,
  input  logic [A_WIDTH-1:0] aWdata,
  input  logic [BAW-1:0]     bAddr,
  input  logic [B_WIDTH-1:0] bWdata,
  output logic [A_WIDTH-1:0] aRdata,
  output logic [B_WIDTH-1:0] bRdata
);

  logic [WORD_DATA-1:0] dataMem [WORDS] = '{default: INIT_DATA};
  logic [WORD_PAR-1:0]  parMem  [WORDS] = '{default: INIT_PAR};

  logic [WW-1:0]        wordA, wordB;
  logic [WORD_DATA-1:0] dMaskA, dValA, dMaskB, dValB;
  logic [WORD_PAR-1:0]  pMaskA, pValA, pMaskB, pValB;
  logic [A_WIDTH-1:0]   rdA;
  logic [B_WIDTH-1:0]   rdB;
  logic [WORD_DATA-1:0] nextDataA, nextDataB, baseDataA;
  logic [WORD_PAR-1:0]  nextParA, nextParB, baseParA;

  asym_dpram_lane_map #(.WIDTH(A_WIDTH), .WORDS(WORDS)) u_mapA (
    .addr(aAddr), .wdata(aWdata),
    .memData(dataMem[wordA]), .memPar(parMem[wordA]),
    .wordIdx(wordA), .dMask(dMaskA), .dVal(dValA),
    .pMask(pMaskA), .pVal(pValA), .rdData(rdA)
  );

  asym_dpram_lane_map #(.WIDTH(B_WIDTH), .WORDS(WORDS)) u_mapB (
    .addr(bAddr), .wdata(bWdata),
    .memData(dataMem[wordB]), .memPar(parMem[wordB]),
    .wordIdx(wordB), .dMask(dMaskB), .dVal(dValB),
    .pMask(pMaskB), .pVal(pValB), .rdData(rdB)
  );

  // B merges first; A merges on top so A wins shared bits of a shared word
  always_comb begin
    nextDataB = (dataMem[wordB] & ~dMaskB) | dValB;
    nextParB  = (parMem[wordB]  & ~pMaskB) | pValB;
    if (stbB.wr && (wordA == wordB)) begin
      baseDataA = nextDataB;
      baseParA  = nextParB;
    end else begin
      baseDataA = dataMem[wordA];
      baseParA  = parMem[wordA];
    end
    nextDataA = (baseDataA & ~dMaskA) | dValA;
    nextParA  = (baseParA  & ~pMaskA) | pValA;
  end

  always_ff @(posedge clk) begin
    if (stbB.wr) begin
      dataMem[wordB] <= nextDataB;
      parMem[wordB]  <= nextParB;
    end
    if (stbA.wr) begin
      dataMem[wordA] <= nextDataA;
      parMem[wordA]  <= nextParA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aRdata <= '0;
      bRdata <= '0;
    end else begin
      if (stbA.echo)      aRdata <= aWdata;
      else if (stbA.load) aRdata <= rdA;
      if (stbB.echo)      bRdata <= bWdata;
      else if (stbB.load) bRdata <= rdB;
    end
  end

endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
  import asym_dpram_pkg::*;
#(
  parameter int       A_WIDTH  = 9,
  parameter int       B_WIDTH  = 36,
  parameter int       WORDS    = 512,
  parameter portcfg_e PORT_CFG = CFG_DUAL,
  parameter wmode_e   A_WMODE  = READ_FIRST,
  parameter wmode_e   B_WMODE  = WRITE_FIRST,
  parameter logic [WORD_DATA-1:0] INIT_DATA = '0,
  parameter logic [WORD_PAR-1:0]  INIT_PAR  = '0
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 aEn,
  input  logic                                 aWe,
  input  logic [addrBits(A_WIDTH, WORDS)-1:0]  aAddr,
  input  logic [A_WIDTH-1:0]                   aWdata,
  output logic [A_WIDTH-1:0]                   aRdata,
  input  logic                                 bEn,
  input  logic                                 bWe,
  input  logic [addrBits(B_WIDTH, WORDS)-1:0]  bAddr,
  input  logic [B_WIDTH-1:0]                   bWdata,
  output logic [B_WIDTH-1:0]                   bRdata
);

  localparam bit A_WR = 1'b1;
  localparam bit A_RD = (PORT_CFG != CFG_SPLIT);
  localparam bit B_WR = (PORT_CFG == CFG_DUAL);
  localparam bit B_RD = (PORT_CFG != CFG_SINGLE);

  stb_t stbA, stbB;

  asym_dpram_port_ctrl #(.CAN_WR(A_WR), .CAN_RD(A_RD), .WMODE(A_WMODE)) u_ctrlA (
    .en(aEn), .we(aWe), .stb(stbA)
  );

  asym_dpram_port_ctrl #(.CAN_WR(B_WR), .CAN_RD(B_RD), .WMODE(B_WMODE)) u_ctrlB (
    .en(bEn), .we(bWe), .stb(stbB)
  );

  asym_dpram_datapath #(
    .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .WORDS(WORDS),
    .INIT_DATA(INIT_DATA), .INIT_PAR(INIT_PAR)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stbA(stbA), .stbB(stbB),
    .aAddr(aAddr), .aWdata(aWdata), .bAddr(bAddr), .bWdata(bWdata),
    .aRdata(aRdata), .bRdata(bRdata)
  );

endmodule

// File: rtl/asym_dpram_chk.sv
module asym_dpram_chk
  import asym_dpram_pkg::*;
#(
  parameter int       A_WIDTH  = 9,
  parameter int       B_WIDTH  = 36,
  parameter int       WORDS    = 512,
  parameter portcfg_e PORT_CFG = CFG_DUAL,
  parameter wmode_e   A_WMODE  = READ_FIRST,
  parameter wmode_e   B_WMODE  = WRITE_FIRST
) (
  input logic                                clk,
  input logic                                rstN,
  input logic                                aEn,
  input logic                                aWe,
  input logic [addrBits(A_WIDTH, WORDS)-1:0] aAddr,
  input logic [A_WIDTH-1:0]                  aWdata,
  input logic [A_WIDTH-1:0]                  aRdata,
  input logic                                bEn,
  input logic                                bWe,
  input logic [addrBits(B_WIDTH, WORDS)-1:0] bAddr,
  input logic [B_WIDTH-1:0]                  bWdata,
  input logic [B_WIDTH-1:0]                  bRdata
);

  localparam bit A_RD = (PORT_CFG != CFG_SPLIT);
  localparam bit B_WR = (PORT_CFG == CFG_DUAL);
  localparam bit B_RD = (PORT_CFG != CFG_SINGLE);

  logic unusedSink;
  assign unusedSink = ^{aAddr, bAddr, aWdata, bWdata, aWe, bWe};

  // R12: outputs are zero while reset is held
  assert_reset_clear_R12: assert property (@(posedge clk)
    !rstN |-> (aRdata == '0 && bRdata == '0));

  // R7: an idle port keeps its output
  assert_a_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !aEn |=> $stable(aRdata));
  assert_b_idle_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !bEn |=> $stable(bRdata));

  generate
    if (A_RD && A_WMODE == NO_CHANGE) begin : g_a_nc
      assert_a_nochange_R6: assert property (@(posedge clk) disable iff (!rstN)
        (aEn && aWe) |=> $stable(aRdata));
    end
    if (A_RD && A_WMODE == WRITE_FIRST) begin : g_a_wf
      assert_a_echo_R5: assert property (@(posedge clk) disable iff (!rstN)
        (aEn && aWe) |=> (aRdata == $past(aWdata)));
    end
    if (B_WR && B_RD && B_WMODE == NO_CHANGE) begin : g_b_nc
      assert_b_nochange_R6: assert property (@(posedge clk) disable iff (!rstN)
        (bEn && bWe) |=> $stable(bRdata));
    end
    if (B_WR && B_RD && B_WMODE == WRITE_FIRST) begin : g_b_wf
      assert_b_echo_R5: assert property (@(posedge clk) disable iff (!rstN)
        (bEn && bWe) |=> (bRdata == $past(bWdata)));
    end
    if (!A_RD) begin : g_a_silent
      assert_a_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
        aRdata == '0);
    end
    if (!B_RD) begin : g_b_silent
      assert_b_silent_R9: assert property (@(posedge clk) disable iff (!rstN)
        bRdata == '0);
    end
  endgenerate

endmodule

bind asym_dpram asym_dpram_chk #(
  .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH), .WORDS(WORDS),
  .PORT_CFG(PORT_CFG), .A_WMODE(A_WMODE), .B_WMODE(B_WMODE)
) u_chk (
  .clk(clk), .rstN(rstN),
  .aEn(aEn), .aWe(aWe), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
  .bEn(bEn), .bWe(bWe), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata)
);

// File: tb/asym_dpram_tb.sv
module asym_dpram_tb;
  import asym_dpram_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b1;
  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // u_dut: dual, A 9-bit read-first, B 36-bit write-first
  logic aEn = 0, aWe = 0, bEn = 0, bWe = 0;
  logic [10:0] aAddr = '0;
  logic [8:0]  aWd = '0, aRd;
  logic [8:0]  bAddr = '0;
  logic [35:0] bWd = '0, bRd;

  asym_dpram #(.A_WIDTH(9), .B_WIDTH(36), .PORT_CFG(CFG_DUAL),
    .A_WMODE(READ_FIRST), .B_WMODE(WRITE_FIRST),
    .INIT_DATA(32'h1234_5678), .INIT_PAR(4'hA)) u_dut (
    .clk(clk), .rstN(rstN), .aEn(aEn), .aWe(aWe), .aAddr(aAddr), .aWdata(aWd),
    .aRdata(aRd), .bEn(bEn), .bWe(bWe), .bAddr(bAddr), .bWdata(bWd), .bRdata(bRd));

  // u_dut2: dual, A 1-bit no-change, B 18-bit read-first
  logic a2En = 0, a2We = 0, b2En = 0, b2We = 0;
  logic [13:0] a2Addr = '0;
  logic [0:0]  a2Wd = '0, a2Rd;
  logic [9:0]  b2Addr = '0;
  logic [17:0] b2Wd = '0, b2Rd;

  asym_dpram #(.A_WIDTH(1), .B_WIDTH(18), .PORT_CFG(CFG_DUAL),
    .A_WMODE(NO_CHANGE), .B_WMODE(READ_FIRST)) u_dut2 (
    .clk(clk), .rstN(rstN), .aEn(a2En), .aWe(a2We), .aAddr(a2Addr), .aWdata(a2Wd),
    .aRdata(a2Rd), .bEn(b2En), .bWe(b2We), .bAddr(b2Addr), .bWdata(b2Wd), .bRdata(b2Rd));

  // u_dut3: split, A 4-bit write-only, B 2-bit read-only
  logic a3En = 0, a3We = 0, b3En = 0, b3We = 0;
  logic [11:0] a3Addr = '0;
  logic [3:0]  a3Wd = '0, a3Rd;
  logic [12:0] b3Addr = '0;
  logic [1:0]  b3Wd = '0, b3Rd;

  asym_dpram #(.A_WIDTH(4), .B_WIDTH(2), .PORT_CFG(CFG_SPLIT)) u_dut3 (
    .clk(clk), .rstN(rstN), .aEn(a3En), .aWe(a3We), .aAddr(a3Addr), .aWdata(a3Wd),
    .aRdata(a3Rd), .bEn(b3En), .bWe(b3We), .bAddr(b3Addr), .bWdata(b3Wd), .bRdata(b3Rd));

  // u_dut4: single, A 36-bit, B 1-bit unused
  logic a4En = 0, a4We = 0, b4En = 0, b4We = 0;
  logic [8:0]  a4Addr = '0;
  logic [35:0] a4Wd = '0, a4Rd;
  logic [13:0] b4Addr = '0;
  logic [0:0]  b4Wd = '0, b4Rd;

  asym_dpram #(.A_WIDTH(36), .B_WIDTH(1), .PORT_CFG(CFG_SINGLE),
    .A_WMODE(READ_FIRST)) u_dut4 (
    .clk(clk), .rstN(rstN), .aEn(a4En), .aWe(a4We), .aAddr(a4Addr), .aWdata(a4Wd),
    .aRdata(a4Rd), .bEn(b4En), .bWe(b4We), .bAddr(b4Addr), .bWdata(b4Wd), .bRdata(b4Rd));

  typedef struct packed {
    logic        aEn;
    logic        aWe;
    logic [10:0] aAddr;
    logic [8:0]  aWd;
    logic        bEn;
    logic        bWe;
    logic [8:0]  bAddr;
    logic [35:0] bWd;
    logic [8:0]  expA;
    logic [35:0] expB;
  } vec_t;

  // word w of u_dut starts as data 1234_5678, parity 1010
  localparam vec_t VEC [10] = '{
    '{1'b1, 1'b0, 11'd0,  9'h000, 1'b1, 1'b0, 9'd1, 36'h0,         9'h078, 36'hA_1234_5678},
    '{1'b1, 1'b1, 11'd1,  9'h1C3, 1'b0, 1'b0, 9'd0, 36'h0,         9'h156, 36'hA_1234_5678},
    '{1'b0, 1'b1, 11'd2,  9'h0FF, 1'b1, 1'b0, 9'd0, 36'h0,         9'h156, 36'hA_1234_C378},
    '{1'b0, 1'b0, 11'd0,  9'h000, 1'b1, 1'b0, 9'd0, 36'h0,         9'h156, 36'hA_1234_C378},
    '{1'b1, 1'b0, 11'd4,  9'h000, 1'b1, 1'b1, 9'd0, 36'h5_DEAD_BEEF, 9'h078, 36'h5_DEAD_BEEF},
    '{1'b1, 1'b0, 11'd3,  9'h000, 1'b1, 1'b0, 9'd0, 36'h0,         9'h0DE, 36'h5_DEAD_BEEF},
    '{1'b1, 1'b1, 11'd8,  9'h011, 1'b1, 1'b1, 9'd3, 36'hF_0000_0001, 9'h078, 36'hF_0000_0001},
    '{1'b1, 1'b0, 11'd12, 9'h000, 1'b1, 1'b0, 9'd2, 36'h0,         9'h101, 36'hA_1234_5611},
    '{1'b1, 1'b1, 11'd16, 9'h0AB, 1'b1, 1'b1, 9'd4, 36'h0,         9'h078, 36'h0},
    '{1'b1, 1'b0, 11'd17, 9'h000, 1'b1, 1'b0, 9'd4, 36'h0,         9'h000, 36'h0_0000_00AB}
  };

  function automatic string rowReq(input int r);
    case (r)
      0: return "R10/R1/R3";
      1: return "R4/R7";
      2: return "R2/R7";
      3: return "R7";
      4: return "R5";
      5: return "R1/R2";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #1 rstN = 1'b0;
    tick();
    tick();
    // R12: reset state of every output
    check("R12 u_dut A", 36'(aRd), 36'h0);
    check("R12 u_dut B", bRd, 36'h0);
    check("R12 u_dut2 B", 36'(b2Rd), 36'h0);
    check("R12 u_dut4 A", a4Rd, 36'h0);
    rstN = 1'b1;
    tick();

    for (int r = 0; r < 10; r++) begin
      aEn = VEC[r].aEn; aWe = VEC[r].aWe; aAddr = VEC[r].aAddr; aWd = VEC[r].aWd;
      bEn = VEC[r].bEn; bWe = VEC[r].bWe; bAddr = VEC[r].bAddr; bWd = VEC[r].bWd;
      tick();
      check($sformatf("%s row %0d port A", rowReq(r), r), 36'(aRd), 36'(VEC[r].expA));
      check($sformatf("%s row %0d port B", rowReq(r), r), bRd, VEC[r].expB);
    end
    aEn = 0; aWe = 0; bEn = 0; bWe = 0;

    // R12: reset mid-run clears outputs and keeps contents
    tick();
    rstN = 1'b0;
    tick();
    check("R12 mid-run clear", bRd, 36'h0);
    rstN = 1'b1;
    bEn = 1; bAddr = 9'd0;
    tick();
    check("R12 contents kept", bRd, 36'h5_DEAD_BEEF);
    bEn = 0;

    // u_dut2: 1-bit no-change port against 18-bit read-first port
    b2En = 1; b2We = 1; b2Addr = 10'd0; b2Wd = 18'h3_8001;
    tick();
    check("R4 u_dut2 B old data", 36'(b2Rd), 36'h0);
    b2We = 0; b2Addr = 10'd1;
    a2En = 1; a2Addr = 14'd0;
    tick();
    check("R1 u_dut2 A bit0", 36'(a2Rd), 36'h1);
    check("R2 u_dut2 B upper slice", 36'(b2Rd), 36'h0);
    b2En = 0;
    a2Addr = 14'd15;
    tick();
    check("R1 u_dut2 A bit15", 36'(a2Rd), 36'h1);
    a2Addr = 14'd1;
    tick();
    check("R1 u_dut2 A bit1", 36'(a2Rd), 36'h0);
    a2Addr = 14'd0;
    tick();
    a2We = 1; a2Addr = 14'd1; a2Wd = 1'b1;
    tick();
    check("R6 u_dut2 A hold on write", 36'(a2Rd), 36'h1);
    a2Addr = 14'd16;
    tick();
    a2En = 0; a2We = 0;
    b2En = 1; b2Addr = 10'd0;
    tick();
    check("R1/R2 u_dut2 B slice0", 36'(b2Rd), 36'h3_8003);
    b2Addr = 10'd1;
    tick();
    check("R2 u_dut2 narrow write spares parity", 36'(b2Rd), 36'h0_0001);
    b2En = 0;

    // u_dut3: split mode
    a3En = 1; a3We = 1; a3Addr = 12'd0; a3Wd = 4'h9;
    tick();
    check("R8 u_dut3 A write-only output", 36'(a3Rd), 36'h0);
    a3En = 0; a3We = 0;
    b3En = 1; b3Addr = 13'd0;
    tick();
    check("R8/R1 u_dut3 B slice0", 36'(b3Rd), 36'h1);
    b3Addr = 13'd1;
    tick();
    check("R8/R1 u_dut3 B slice1", 36'(b3Rd), 36'h2);
    b3We = 1; b3Addr = 13'd0; b3Wd = 2'b10;
    a3En = 1; a3We = 0; a3Addr = 12'd0;
    tick();
    check("R8 u_dut3 B we reads", 36'(b3Rd), 36'h1);
    check("R8 u_dut3 A read attempt", 36'(a3Rd), 36'h0);
    b3We = 0; a3En = 0;
    tick();
    check("R8 u_dut3 B write ignored", 36'(b3Rd), 36'h1);
    b3En = 0;

    // u_dut4: single-port mode
    a4En = 1; a4We = 1; a4Addr = 9'd5; a4Wd = 36'h1_0000_0000;
    tick();
    check("R4 u_dut4 A old data", a4Rd, 36'h0);
    a4En = 0; a4We = 0;
    b4En = 1; b4We = 1; b4Addr = 14'd160; b4Wd = 1'b1;
    tick();
    check("R9 u_dut4 B on write", 36'(b4Rd), 36'h0);
    b4We = 0;
    tick();
    check("R9 u_dut4 B on read", 36'(b4Rd), 36'h0);
    b4En = 0;
    a4En = 1; a4Addr = 9'd5;
    tick();
    check("R9 u_dut4 B write ignored", a4Rd, 36'h1_0000_0000);
    a4En = 0;

    tick();
    summary();
  end

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

endmodule